// File: doc/BRIEF.md
# Return Address Stack

This block keeps the return addresses of a small processor core. Each of the 31 entries holds a 21-bit program counter value. A 5-bit pointer selects the current top entry, and pointer value 0 means the stack is empty. A call or an explicit push stores the supplied PC in the next entry. A return or an explicit pop drops the top entry. A return also hands the dropped value back to the core on the following cycle.

Software sees four byte registers. One register holds the two sticky error flags and the pointer. The other three are windows onto the upper, high and low bytes of the current top entry. Software can therefore push a value and then rewrite it byte by byte, or move the pointer directly. Overflow and underflow set their flags. When the configuration enable is on, the block also pulses a reset request for the external reset generator.

Top module: `ret_addr_stack`

## Requirements
- R1: A push (`push_i` or `call_i`) with the pointer below 31 increments the pointer and stores `pc_i` in the newly addressed entry. `tos_o` shows the stored value on the cycle after the push edge.
- R2: A pop (`pop_i` or `ret_i`) with the pointer above 0 decrements the pointer, so `tos_o` shows the previously pushed value. When the pop comes from `ret_i`, `ret_vld_o` is high for one cycle after the edge and `ret_pc_o` holds the old top value.
- R3: Register reads are combinational on `reg_addr_i`. Address 0 is status: bit 7 full flag, bit 6 underflow flag, bit 5 always 0, bits 4:0 pointer. Address 1 is the upper byte, with entry bits 20:16 in bits 4:0 and bits 7:5 reading 0. Address 2 is entry bits 15:8. Address 3 is entry bits 7:0.
- R4: A write to address 1, 2 or 3 replaces only that byte of the entry under the pointer. Such a write is ignored while the pointer is 0, and `tos_o` then reads 0.
- R5: A push that brings the pointer to 31 sets the full flag. A push at pointer 31 sets the full flag, leaves the pointer at 31 and leaves entry 31 unchanged.
- R6: A pop or return at pointer 0 sets the underflow flag and leaves the pointer at 0. `tos_o` reads 0, and a return then delivers `ret_pc_o` = 0.
- R7: Both flags are sticky. A status write loads bits 4:0 into the pointer and clears a flag whose bit is written 0. Writing 1 to a flag bit leaves that flag unchanged.
- R8: A push strobe and a pop strobe in the same cycle are ignored. Pointer, flags and entries are unchanged, and `ret_vld_o` stays low.
- R9: With `stk_rst_en_i` high, every full or underflow event gives a one-cycle `rst_req_o` pulse on the cycle after the edge, when the flag is already visible. With it low, `rst_req_o` stays 0.
- R10: After `rst_n` low, the pointer, both flags, `rst_req_o` and `ret_vld_o` are 0.
- R11: A register write in a cycle with any push or pop strobe is ignored, and the stack operation takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low |
| push_i | input | 1 | Explicit push of `pc_i` |
| pop_i | input | 1 | Explicit pop |
| call_i | input | 1 | Call: push of `pc_i` as return address |
| ret_i | input | 1 | Return: pop that outputs the old top |
| pc_i | input | 21 | Value to push |
| stk_rst_en_i | input | 1 | Enables reset requests on full or underflow |
| reg_wr_i | input | 1 | Software register write strobe |
| reg_addr_i | input | 2 | Register select (0 status, 1 upper, 2 high, 3 low) |
| reg_wdata_i | input | 8 | Software write data |
| reg_rdata_o | output | 8 | Software read data (combinational) |
| tos_o | output | 21 | Current top-of-stack value |
| ret_vld_o | output | 1 | Return value valid |
| ret_pc_o | output | 21 | Returned address |
| rst_req_o | output | 1 | Reset request pulse |

## Verification
Every stack operation, flag update, register write and reset request comes from one register stage. The result of a strobe applied before edge k is therefore due just after edge k. Register reads have no register stage and are due as soon as the address settles. The bench drives inputs on the falling edge and samples all registered results on the next falling edge, which is one rising edge later. Register reads are sampled a short delay after the address is set, in the same half cycle. The reset-request pulse is checked on that cycle and again one idle cycle later, when it must have dropped.

// File: rtl/ras_pkg.sv
`timescale 1ns/1ps
package ras_pkg;
    typedef enum logic [1:0] {
        RA_STAT  = 2'd0,
        RA_UPPER = 2'd1,
        RA_HIGH  = 2'd2,
        RA_LOW   = 2'd3
    } ras_reg_e;

    localparam int unsigned FULL_BIT = 7;
    localparam int unsigned UNF_BIT  = 6;
endpackage

// File: rtl/ras_ctrl.sv
`timescale 1ns/1ps
module ras_ctrl #(
    parameter int unsigned PTR_W = 5
) (
    input  logic             push_i,
    input  logic             pop_i,
    input  logic             call_i,
    input  logic             ret_i,
    input  logic [PTR_W-1:0] ptr_q,
    output logic             wr_push,
    output logic             mv_pop,
    output logic             full_evt,
    output logic             unf_evt,
    output logic             ret_evt,
    output logic             busy
);
    localparam logic [PTR_W-1:0] TOP = {PTR_W{1'b1}};

    logic push_req, pop_req, clash, at_top, empty;

    always_comb begin
        push_req = push_i | call_i;
        pop_req  = pop_i | ret_i;
        clash    = push_req & pop_req;
        at_top   = (ptr_q == TOP);
        empty    = (ptr_q == '0);
        busy     = push_req | pop_req;
        wr_push  = push_req & ~clash & ~at_top;
        full_evt = push_req & ~clash & (at_top | (ptr_q == TOP - 1'b1));
        mv_pop   = pop_req & ~clash & ~empty;
        unf_evt  = pop_req & ~clash & empty;
        ret_evt  = ret_i & pop_req & ~clash;
    end
endmodule

// File: rtl/ras_regif.sv
`timescale 1ns/1ps
module ras_regif
    import ras_pkg::*;
#(
    parameter int unsigned PC_W  = 21,
    parameter int unsigned PTR_W = 5
) (
    input  logic             reg_wr_i,
    input  logic [1:0]       reg_addr_i,
    input  logic [7:0]       reg_wdata_i,
    input  logic             busy,
    input  logic [PC_W-1:0]  tos,
    input  logic [PTR_W-1:0] ptr_q,
    input  logic             full_q,
    input  logic             unf_q,
    output logic [7:0]       reg_rdata_o,
    output logic             stat_wr,
    output logic [PTR_W-1:0] ptr_wval,
    output logic             full_nxt,
    output logic             unf_nxt,
    output logic             tos_wr,
    output logic [PC_W-1:0]  tos_wval
);
    localparam int unsigned UPW = PC_W - 16;

    ras_reg_e sel;
    logic     wr_ok;

    always_comb begin
        sel         = ras_reg_e'(reg_addr_i);
        reg_rdata_o = '0;
        case (sel)
            RA_STAT: begin
                reg_rdata_o[FULL_BIT]  = full_q;
                reg_rdata_o[UNF_BIT]   = unf_q;
                reg_rdata_o[PTR_W-1:0] = ptr_q;
            end
            RA_UPPER: reg_rdata_o[UPW-1:0] = tos[PC_W-1:16];
            RA_HIGH:  reg_rdata_o = tos[15:8];
            default:  reg_rdata_o = tos[7:0];
        endcase

        wr_ok    = reg_wr_i & ~busy;
        stat_wr  = wr_ok & (sel == RA_STAT);
        ptr_wval = reg_wdata_i[PTR_W-1:0];
        full_nxt = full_q & reg_wdata_i[FULL_BIT];
        unf_nxt  = unf_q & reg_wdata_i[UNF_BIT];

        tos_wr   = wr_ok & (sel != RA_STAT) & (ptr_q != '0);
        tos_wval = tos;
        case (sel)
            RA_UPPER: tos_wval[PC_W-1:16] = reg_wdata_i[UPW-1:0];
            RA_HIGH:  tos_wval[15:8]      = reg_wdata_i;
            RA_LOW:   tos_wval[7:0]       = reg_wdata_i;
            default:  tos_wval            = tos;
        endcase
    end
endmodule

// File: rtl/ras_entry_store.sv
`timescale 1ns/1ps
module ras_entry_store #(
    parameter int unsigned PC_W  = 21,
    parameter int unsigned PTR_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [PTR_W-1:0] waddr,
    input  logic [PC_W-1:0]  wdata,
    input  logic [PTR_W-1:0] raddr,
    output logic [PC_W-1:0]  rdata
);
    localparam int unsigned DEPTH = (1 << PTR_W) - 1;

    logic [PC_W-1:0] slot_flat [0:DEPTH];

    assign slot_flat[0] = '0;

    for (genvar g = 1; g <= DEPTH; g++) begin : g_slot
        logic [PC_W-1:0] slot_d, slot_q;

        always_comb begin
            slot_d = slot_q;
            if (we && (waddr == PTR_W'(g))) slot_d = wdata;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) slot_q <= '0;
            else        slot_q <= slot_d;
        end

        assign slot_flat[g] = slot_q;
    end

    assign rdata = slot_flat[raddr];
endmodule

// File: rtl/ret_addr_stack.sv
`timescale 1ns/1ps
module ret_addr_stack #(
    parameter int unsigned PC_W  = 21,
    parameter int unsigned PTR_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic             pop_i,
    input  logic             call_i,
    input  logic             ret_i,
    input  logic [PC_W-1:0]  pc_i,
    input  logic             stk_rst_en_i,
    input  logic             reg_wr_i,
    input  logic [1:0]       reg_addr_i,
    input  logic [7:0]       reg_wdata_i,
    output logic [7:0]       reg_rdata_o,
    output logic [PC_W-1:0]  tos_o,
    output logic             ret_vld_o,
    output logic [PC_W-1:0]  ret_pc_o,
    output logic             rst_req_o
);
    typedef struct packed {
        logic [PTR_W-1:0] ptr;
        logic             full;
        logic             unf;
        logic             rst_req;
        logic             ret_vld;
        logic [PC_W-1:0]  ret_pc;
    } ras_state_t;

    ras_state_t state_d, state_q;

    logic [PTR_W-1:0] ptr_q;
    logic             full_q, unf_q;
    logic             wr_push, mv_pop, full_evt, unf_evt, ret_evt, busy;
    logic             stat_wr, full_nxt, unf_nxt, tos_wr;
    logic [PTR_W-1:0] ptr_wval;
    logic [PC_W-1:0]  tos_wval, tos;
    logic             st_we;
    logic [PTR_W-1:0] st_waddr;
    logic [PC_W-1:0]  st_wdata;

    assign ptr_q  = state_q.ptr;
    assign full_q = state_q.full;
    assign unf_q  = state_q.unf;

    ras_ctrl #(.PTR_W(PTR_W)) u_ctrl (
        .push_i   (push_i),
        .pop_i    (pop_i),
        .call_i   (call_i),
        .ret_i    (ret_i),
        .ptr_q    (ptr_q),
        .wr_push  (wr_push),
        .mv_pop   (mv_pop),
        .full_evt (full_evt),
        .unf_evt  (unf_evt),
        .ret_evt  (ret_evt),
        .busy     (busy)
    );

    ras_regif #(.PC_W(PC_W), .PTR_W(PTR_W)) u_regif (
        .reg_wr_i    (reg_wr_i),
        .reg_addr_i  (reg_addr_i),
        .reg_wdata_i (reg_wdata_i),
        .busy        (busy),
        .tos         (tos),
        .ptr_q       (ptr_q),
        .full_q      (full_q),
        .unf_q       (unf_q),
        .reg_rdata_o (reg_rdata_o),
        .stat_wr     (stat_wr),
        .ptr_wval    (ptr_wval),
        .full_nxt    (full_nxt),
        .unf_nxt     (unf_nxt),
        .tos_wr      (tos_wr),
        .tos_wval    (tos_wval)
    );

    ras_entry_store #(.PC_W(PC_W), .PTR_W(PTR_W)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (st_we),
        .waddr (st_waddr),
        .wdata (st_wdata),
        .raddr (ptr_q),
        .rdata (tos)
    );

    always_comb begin
        st_we    = wr_push | tos_wr;
        st_waddr = wr_push ? ptr_q + 1'b1 : ptr_q;
        st_wdata = wr_push ? pc_i : tos_wval;

        state_d         = state_q;
        state_d.rst_req = stk_rst_en_i & (full_evt | unf_evt);
        state_d.ret_vld = ret_evt;
        if (ret_evt)  state_d.ret_pc = tos;
        if (wr_push)  state_d.ptr    = ptr_q + 1'b1;
        if (mv_pop)   state_d.ptr    = ptr_q - 1'b1;
        if (full_evt) state_d.full   = 1'b1;
        if (unf_evt)  state_d.unf    = 1'b1;
        if (stat_wr) begin
            state_d.ptr  = ptr_wval;
            state_d.full = full_nxt;
            state_d.unf  = unf_nxt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign tos_o     = tos;
    assign ret_vld_o = state_q.ret_vld;
    assign ret_pc_o  = state_q.ret_pc;
    assign rst_req_o = state_q.rst_req;
endmodule

// File: rtl/ras_chk.sv
`timescale 1ns/1ps
module ras_chk #(
    parameter int unsigned PC_W  = 21,
    parameter int unsigned PTR_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             push_i,
    input logic             pop_i,
    input logic             call_i,
    input logic             ret_i,
    input logic             stk_rst_en_i,
    input logic             reg_wr_i,
    input logic [1:0]       reg_addr_i,
    input logic [7:0]       reg_wdata_i,
    input logic [7:0]       reg_rdata_o,
    input logic [PC_W-1:0]  tos_o,
    input logic             ret_vld_o,
    input logic             rst_req_o,
    input logic [PTR_W-1:0] ptr_q,
    input logic             full_q,
    input logic             unf_q
);
    localparam logic [PTR_W-1:0] TOP = {PTR_W{1'b1}};

    logic psh, pp;
    assign psh = push_i | call_i;
    assign pp  = pop_i | ret_i;

    a_r1_push_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (psh && !pp && ptr_q != TOP) |=> ptr_q == $past(ptr_q) + 1'b1);

    a_r2_pop_retreat: assert property (@(posedge clk) disable iff (!rst_n)
        (pp && !psh && ptr_q != '0) |=> ptr_q == $past(ptr_q) - 1'b1);

    a_r5_full_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (psh && !pp && ptr_q == TOP) |=> (ptr_q == TOP && full_q && $stable(tos_o)));

    a_r6_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        (pp && !psh && ptr_q == '0) |=> (ptr_q == '0 && unf_q && tos_o == '0));

    a_r7_full_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (full_q && !(reg_wr_i && reg_addr_i == 2'd0 && !reg_wdata_i[7])) |=> full_q);

    a_r7_unf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (unf_q && !(reg_wr_i && reg_addr_i == 2'd0 && !reg_wdata_i[6])) |=> unf_q);

    a_r8_clash_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (psh && pp) |=> ($stable(ptr_q) && !ret_vld_o));

    a_r9_req_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_o |-> (full_q || unf_q));

    a_r9_req_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        !stk_rst_en_i |=> !rst_req_o);

    always_comb begin
        if (rst_n && reg_addr_i == 2'd0) begin
            a_r3_bit5_zero: assert (reg_rdata_o[5] == 1'b0);
        end
    end
endmodule

bind ret_addr_stack ras_chk #(.PC_W(PC_W), .PTR_W(PTR_W)) u_ras_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .push_i       (push_i),
    .pop_i        (pop_i),
    .call_i       (call_i),
    .ret_i        (ret_i),
    .stk_rst_en_i (stk_rst_en_i),
    .reg_wr_i     (reg_wr_i),
    .reg_addr_i   (reg_addr_i),
    .reg_wdata_i  (reg_wdata_i),
    .reg_rdata_o  (reg_rdata_o),
    .tos_o        (tos_o),
    .ret_vld_o    (ret_vld_o),
    .rst_req_o    (rst_req_o),
    .ptr_q        (ptr_q),
    .full_q       (full_q),
    .unf_q        (unf_q)
);

// File: tb/test_ret_addr_stack.sv
`timescale 1ns/1ps
module test_ret_addr_stack;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        push_i = 0, pop_i = 0, call_i = 0, ret_i = 0;
    logic [20:0] pc_i = '0;
    logic        stk_rst_en_i = 0;
    logic        reg_wr_i = 0;
    logic [1:0]  reg_addr_i = '0;
    logic [7:0]  reg_wdata_i = '0;
    logic [7:0]  reg_rdata_o;
    logic [20:0] tos_o, ret_pc_o;
    logic        ret_vld_o, rst_req_o;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    ret_addr_stack i_ret_addr_stack (
        .clk(clk), .rst_n(rst_n), .push_i(push_i), .pop_i(pop_i),
        .call_i(call_i), .ret_i(ret_i), .pc_i(pc_i),
        .stk_rst_en_i(stk_rst_en_i), .reg_wr_i(reg_wr_i),
        .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
        .reg_rdata_o(reg_rdata_o), .tos_o(tos_o), .ret_vld_o(ret_vld_o),
        .ret_pc_o(ret_pc_o), .rst_req_o(rst_req_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic op(input logic pu, input logic po, input logic ca, input logic re,
                      input logic [20:0] pc);
        push_i = pu; pop_i = po; call_i = ca; ret_i = re; pc_i = pc;
        step();
        push_i = 0; pop_i = 0; call_i = 0; ret_i = 0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        reg_wr_i = 1; reg_addr_i = a; reg_wdata_i = d;
        step();
        reg_wr_i = 0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        reg_addr_i = a;
        #1;
        d = reg_rdata_o;
    endtask

    task automatic t_reset();
        logic [7:0] s;
        rd(2'd0, s);
        chk("R10 status after reset", s, 8'h00);
        chk("R10 rst_req after reset", rst_req_o, 0);
        chk("R10 ret_vld after reset", ret_vld_o, 0);
        chk("R6 tos empty", tos_o, 0);
    endtask

    task automatic t_push_pop();
        logic [7:0] s;
        op(1, 0, 0, 0, 21'h001A34);
        rd(2'd0, s);
        chk("R1 ptr after push", s, 8'h01);
        chk("R1 tos after push", tos_o, 21'h001A34);
        op(0, 0, 1, 0, 21'h000D58);
        chk("R1 tos after call", tos_o, 21'h000D58);
        op(0, 0, 0, 1, '0);
        chk("R2 ret_vld", ret_vld_o, 1);
        chk("R2 ret_pc old top", ret_pc_o, 21'h000D58);
        chk("R2 tos previous", tos_o, 21'h001A34);
        step();
        chk("R2 ret_vld one cycle", ret_vld_o, 0);
        op(0, 1, 0, 0, '0);
        rd(2'd0, s);
        chk("R2 ptr after pop", s, 8'h00);
    endtask

    task automatic t_tos_bytes();
        logic [7:0] s;
        op(1, 0, 0, 0, 21'h012345);
        rd(2'd1, s); chk("R3 upper byte", s, 8'h01);
        rd(2'd2, s); chk("R3 high byte", s, 8'h23);
        rd(2'd3, s); chk("R3 low byte", s, 8'h45);
        wr(2'd1, 8'hEA);
        rd(2'd1, s); chk("R3 upper masked", s, 8'h0A);
        chk("R4 upper only", tos_o, 21'h0A2345);
        wr(2'd2, 8'h55);
        wr(2'd3, 8'hAA);
        chk("R4 all bytes", tos_o, 21'h0A55AA);
        wr(2'd0, 8'h20);
        rd(2'd0, s); chk("R3 bit5 reads zero", s, 8'h00);
        wr(2'd3, 8'h99);
        chk("R4 write at empty ignored", tos_o, 0);
        wr(2'd0, 8'h01);
        chk("R4 entry kept", tos_o, 21'h0A55AA);
        wr(2'd0, 8'h00);
    endtask

    task automatic t_underflow();
        logic [7:0] s;
        stk_rst_en_i = 0;
        op(0, 0, 0, 1, '0);
        rd(2'd0, s);
        chk("R6 unf set ptr 0", s, 8'h40);
        chk("R6 ret_pc zero", ret_pc_o, 0);
        chk("R6 ret_vld", ret_vld_o, 1);
        chk("R9 no req when disabled", rst_req_o, 0);
        wr(2'd0, 8'h40);
        rd(2'd0, s); chk("R7 write 1 keeps unf", s, 8'h40);
        wr(2'd0, 8'h00);
        rd(2'd0, s); chk("R7 write 0 clears unf", s, 8'h00);
        stk_rst_en_i = 1;
        op(0, 1, 0, 0, '0);
        chk("R9 req on underflow", rst_req_o, 1);
        step();
        chk("R9 req one cycle", rst_req_o, 0);
        rd(2'd0, s); chk("R7 unf sticky", s, 8'h40);
        wr(2'd0, 8'h00);
    endtask

    task automatic t_full();
        logic [7:0] s;
        stk_rst_en_i = 1;
        wr(2'd0, 8'h1E);
        rd(2'd0, s); chk("R7 ptr load", s, 8'h1E);
        op(1, 0, 0, 0, 21'h011111);
        rd(2'd0, s); chk("R5 full at 31", s, 8'h9F);
        chk("R5 tos 31", tos_o, 21'h011111);
        chk("R9 req on full", rst_req_o, 1);
        step();
        chk("R9 req dropped", rst_req_o, 0);
        op(1, 0, 0, 0, 21'h022222);
        rd(2'd0, s); chk("R5 ptr holds", s, 8'h9F);
        chk("R5 entry not overwritten", tos_o, 21'h011111);
        chk("R9 req on push while full", rst_req_o, 1);
        wr(2'd0, 8'h9F);
        rd(2'd0, s); chk("R7 write 1 keeps full", s, 8'h9F);
        wr(2'd0, 8'h1F);
        rd(2'd0, s); chk("R7 clear full", s, 8'h1F);
        stk_rst_en_i = 0;
    endtask

    task automatic t_clash();
        logic [7:0] s;
        wr(2'd0, 8'h02);
        chk("R7 ptr moved to 2", tos_o, 21'h000D58);
        op(1, 1, 0, 0, 21'h000003);
        rd(2'd0, s); chk("R8 ptr unchanged", s, 8'h02);
        chk("R8 tos unchanged", tos_o, 21'h000D58);
        op(0, 0, 1, 1, 21'h000004);
        chk("R8 no ret_vld", ret_vld_o, 0);
        rd(2'd0, s); chk("R8 ptr still 2", s, 8'h02);
        reg_wr_i = 1; reg_addr_i = 2'd0; reg_wdata_i = 8'h00;
        op(1, 0, 0, 0, 21'h007777);
        reg_wr_i = 0;
        rd(2'd0, s); chk("R11 push wins over write", s, 8'h03);
        chk("R11 pushed value", tos_o, 21'h007777);
    endtask

    initial begin
        #(8 * 100000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_push_pop();
        t_tos_bytes();
        t_underflow();
        t_full();
        t_clash();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule